// File: doc/BRIEF.md
# USB Host Pipe Token Scheduler

This block decides, once per scheduling slot, whether one host-side USB pipe may start a transaction and which token it issues: SETUP, IN or OUT. It looks at whether host operation and the downstream bus are both active, the pipe's transfer kind, its direction, its response mode, a pending setup request and the state of the pipe buffer. Periodic pipes (interrupt and isochronous) are also gated by a frame-interval counter that is clocked by start-of-frame strobes.

Once a request is raised it stays up, with its token type and flags unchanged, until the transaction engine returns a done pulse. Isochronous pipes never wait for the buffer. An isochronous OUT with nothing to send asks for a zero-length packet. An isochronous IN with no room marks the incoming packet for discard. Packet framing, CRC, handshakes and the buffer memory sit outside this block.

Top module: `usbh_pipe_sched`

## Requirements
- R1: No request is raised while `host_mode` or `bus_active` is 0. Dropping either one cancels a held request on the next clock edge and reloads the interval counter.
- R2: While `setup_req` is 1, a SETUP request (type 01) is raised whatever the direction, response mode, buffer state and interval state.
- R3: Control and bulk pipes (`xfer_type` 00 and 01) raise IN (10) when `dir_out`=0, the response mode is BUF (01) and `rx_space`=1. They raise OUT (11) when `dir_out`=1, the mode is BUF and `tx_ready`=1. The interval counter plays no part.
- R4: Interrupt pipes (`xfer_type` 10) follow the buffer rules of R3 but raise a request only in an interval-matched frame.
- R5: Isochronous IN (`xfer_type` 11, `dir_out`=0) in BUF mode raises IN in every matched frame. `discard` is 1 exactly when `rx_space` was 0 at issue.
- R6: Isochronous OUT in BUF mode raises OUT in every matched frame. `zlp` is 1 exactly when `tx_ready` was 0 at issue.
- R7: The interval counter loads `ivl_m1` while the pipe is inactive and counts down on each `sof`. A frame is matched from the strobe that brings it to 0 until the next strobe, which reloads it. This gives a match every `ivl_m1`+1 frames, and the first match comes after `ivl_m1` strobes.
- R8: A periodic pipe raises at most one IN/OUT request per frame, even after that request completes.
- R9: A raised request holds `tok_req`, `tok_type`, `zlp` and `discard` steady until `xfer_done`. After the edge that samples `xfer_done`, `tok_req` is 0 for at least one cycle.
- R10: A response mode other than BUF (00 NAK, 10/11 STALL) blocks IN and OUT requests.
- R11: After reset, and whenever no request is held, `tok_req`=0, `tok_type`=00, `zlp`=0 and `discard`=0.
- R12: No new request is raised on the clock edge that samples `sof`=1. The decision waits for the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_mode | input | 1 | Host operation selected |
| bus_active | input | 1 | Downstream port enabled |
| xfer_type | input | 2 | 00 control, 01 bulk, 10 interrupt, 11 isochronous |
| dir_out | input | 1 | 1 = OUT pipe, 0 = IN pipe |
| resp_mode | input | 2 | 00 NAK, 01 BUF, 10/11 STALL |
| setup_req | input | 1 | Setup stage requested |
| rx_space | input | 1 | Buffer has room for a received packet |
| tx_ready | input | 1 | Buffer holds data to send |
| ivl_m1 | input | IVL_W | Interval in frames minus one |
| sof | input | 1 | Start-of-frame strobe, one cycle |
| xfer_done | input | 1 | Transaction finished, releases the request |
| tok_req | output | 1 | Request held |
| tok_type | output | 2 | 00 none, 01 SETUP, 10 IN, 11 OUT |
| zlp | output | 1 | Send a zero-length packet |
| discard | output | 1 | Discard the received packet |

## Verification
On every cycle, assertions check that the bus gate holds, that a held request keeps its type until done, that it falls after done, that the idle outputs are zero, and that `zlp` and `discard` appear only with OUT and IN respectively. They also check that no request starts on a strobe edge, that the counter steps by one per strobe, and that no second periodic request is raised within a frame. The bench scenarios are needed to show the things a per-cycle property cannot see: the period and phase of matched frames for a given interval, the choice among SETUP, IN and OUT under mixed inputs, and how the isochronous fallback flags follow the buffer state.

// File: rtl/usbh_sched_pkg.sv
package usbh_sched_pkg;

  typedef enum logic [1:0] {XF_CTRL = 2'b00, XF_BULK = 2'b01, XF_INTR = 2'b10, XF_ISO = 2'b11} xfer_e;
  typedef enum logic [1:0] {RM_NAK = 2'b00, RM_BUF = 2'b01, RM_STALL = 2'b10, RM_STALL_ALT = 2'b11} resp_e;
  typedef enum logic [1:0] {TK_NONE = 2'b00, TK_SETUP = 2'b01, TK_IN = 2'b10, TK_OUT = 2'b11} tok_e;

  typedef struct packed {
    tok_e tok;
    logic zlp;
    logic discard;
  } grant_t;

  function automatic logic is_periodic(xfer_e t);
    return (t == XF_INTR) || (t == XF_ISO);
  endfunction

  // Which token this pipe could issue in the current slot, ignoring holds.
  function automatic grant_t pick_token(xfer_e t, logic is_out, resp_e rm,
                                        logic setup, logic rx, logic tx,
                                        logic hit);
    grant_t g;
    g = '{tok: TK_NONE, zlp: 1'b0, discard: 1'b0};
    if (setup) begin
      g.tok = TK_SETUP;
    end else if (rm == RM_BUF && (!is_periodic(t) || hit)) begin
      if (t == XF_ISO) begin
        g.tok     = is_out ? TK_OUT : TK_IN;
        g.zlp     = is_out && !tx;
        g.discard = !is_out && !rx;
      end else if (is_out && tx) begin
        g.tok = TK_OUT;
      end else if (!is_out && rx) begin
        g.tok = TK_IN;
      end
    end
    return g;
  endfunction

endpackage

// File: rtl/usbh_ivl_timer.sv
module usbh_ivl_timer #(
  parameter int IVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             sof,
  input  logic [IVL_W-1:0] ivl_m1,
  output logic             frame_hit
);
  logic [IVL_W-1:0] cnt;
  logic             at_zero;

  assign at_zero   = (cnt == '0);
  assign frame_hit = run && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= ivl_m1;
    else if (sof)     cnt <= at_zero ? ivl_m1 : cnt - 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run && sof && !at_zero |=> cnt == $past(cnt) - 1'b1) else $error("count step"); // R7
  AST_RELOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == $past(ivl_m1)) else $error("idle reload"); // R1
endmodule

// File: rtl/usbh_tok_decide.sv
module usbh_tok_decide
  import usbh_sched_pkg::*;
(
  input  xfer_e  xfer,
  input  logic   is_out,
  input  resp_e  rm,
  input  logic   setup,
  input  logic   rx,
  input  logic   tx,
  input  logic   hit,
  output grant_t grant,
  output logic   periodic_tok
);
  always_comb begin
    grant        = pick_token(xfer, is_out, rm, setup, rx, tx, hit);
    periodic_tok = is_periodic(xfer) && (grant.tok == TK_IN || grant.tok == TK_OUT);
  end
endmodule

// File: rtl/usbh_req_hold.sv
module usbh_req_hold
  import usbh_sched_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  input  logic   sof,
  input  grant_t grant,
  input  logic   periodic_tok,
  input  logic   xfer_done,
  output logic   pend,
  output tok_e   tok_q,
  output logic   zlp_q,
  output logic   disc_q
);
  logic used;
  logic issue;
  logic issue_periodic;

  assign issue = run && !pend && !sof && (grant.tok != TK_NONE)
                 && !(periodic_tok && used);
  assign issue_periodic = issue && periodic_tok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0; tok_q <= TK_NONE; zlp_q <= 1'b0; disc_q <= 1'b0; used <= 1'b0;
    end else if (!run) begin
      pend <= 1'b0; tok_q <= TK_NONE; zlp_q <= 1'b0; disc_q <= 1'b0; used <= 1'b0;
    end else begin
      if (sof) used <= 1'b0;
      else if (issue_periodic) used <= 1'b1;
      if (issue) begin
        pend <= 1'b1; tok_q <= grant.tok; zlp_q <= grant.zlp; disc_q <= grant.discard;
      end else if (pend && xfer_done) begin
        pend <= 1'b0; tok_q <= TK_NONE; zlp_q <= 1'b0; disc_q <= 1'b0;
      end
    end
  end

  AST_ONE_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    used && !sof |-> !issue_periodic) else $error("second periodic issue"); // R8
  AST_NO_ISSUE_AT_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> !$rose(pend)) else $error("issue on sof edge"); // R12
  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !xfer_done && run |=> pend && $stable(tok_q) && $stable(zlp_q) && $stable(disc_q))
    else $error("request changed while held"); // R9
endmodule

// File: rtl/usbh_pipe_sched.sv
module usbh_pipe_sched
  import usbh_sched_pkg::*;
#(
  parameter int IVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_mode,
  input  logic             bus_active,
  input  logic [1:0]       xfer_type,
  input  logic             dir_out,
  input  logic [1:0]       resp_mode,
  input  logic             setup_req,
  input  logic             rx_space,
  input  logic             tx_ready,
  input  logic [IVL_W-1:0] ivl_m1,
  input  logic             sof,
  input  logic             xfer_done,
  output logic             tok_req,
  output logic [1:0]       tok_type,
  output logic             zlp,
  output logic             discard
);
  logic   run;
  logic   frame_hit;
  grant_t grant;
  logic   periodic_tok;
  logic   pend;
  tok_e   tok_q;
  logic   zlp_q;
  logic   disc_q;

  assign run = host_mode && bus_active;

  usbh_ivl_timer #(.IVL_W(IVL_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .sof(sof), .ivl_m1(ivl_m1), .frame_hit(frame_hit)
  );

  usbh_tok_decide u_decide (
    .xfer(xfer_e'(xfer_type)), .is_out(dir_out), .rm(resp_e'(resp_mode)),
    .setup(setup_req), .rx(rx_space), .tx(tx_ready), .hit(frame_hit),
    .grant(grant), .periodic_tok(periodic_tok)
  );

  usbh_req_hold u_hold (
    .clk(clk), .rst_n(rst_n), .run(run), .sof(sof), .grant(grant),
    .periodic_tok(periodic_tok), .xfer_done(xfer_done),
    .pend(pend), .tok_q(tok_q), .zlp_q(zlp_q), .disc_q(disc_q)
  );

  assign tok_req  = pend;
  assign tok_type = tok_q;
  assign zlp      = zlp_q;
  assign discard  = disc_q;

  AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tok_req) else $error("request while inactive"); // R1
  AST_DONE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    tok_req && xfer_done |=> !tok_req) else $error("request kept after done"); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_req |-> tok_type == 2'b00 && !zlp && !discard) else $error("idle outputs"); // R11
  AST_ZLP_IS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    zlp |-> tok_type == 2'b11) else $error("zlp without OUT"); // R6
  AST_DISC_IS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    discard |-> tok_type == 2'b10) else $error("discard without IN"); // R5
endmodule

// File: tb/tb_usbh_pipe_sched.sv
`timescale 1ns/1ps
module tb_usbh_pipe_sched;
  localparam int IVL_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_mode = 0, bus_active = 0, dir_out = 0, setup_req = 0;
  logic rx_space = 0, tx_ready = 0, sof = 0, xfer_done = 0;
  logic [1:0] xfer_type = 2'b01, resp_mode = 2'b01;
  logic [IVL_W-1:0] ivl_m1 = '0;
  logic tok_req, zlp, discard;
  logic [1:0] tok_type;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  usbh_pipe_sched #(.IVL_W(IVL_W)) dut (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .bus_active(bus_active),
    .xfer_type(xfer_type), .dir_out(dir_out), .resp_mode(resp_mode),
    .setup_req(setup_req), .rx_space(rx_space), .tx_ready(tx_ready),
    .ivl_m1(ivl_m1), .sof(sof), .xfer_done(xfer_done),
    .tok_req(tok_req), .tok_type(tok_type), .zlp(zlp), .discard(discard)
  );

  task automatic tick(); @(posedge clk); #1; endtask

  // expected word: {tok_req, tok_type, zlp, discard}
  task automatic expect_out(string req, logic [4:0] exp);
    logic [4:0] act;
    act = {tok_req, tok_type, zlp, discard};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {req,type,zlp,disc} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic pipe(logic [1:0] t, logic o, logic [1:0] rm, logic rx, logic tx);
    xfer_type = t; dir_out = o; resp_mode = rm; rx_space = rx; tx_ready = tx;
  endtask

  task automatic go_idle(logic [IVL_W-1:0] iv);
    bus_active = 0; setup_req = 0; xfer_done = 0; sof = 0; ivl_m1 = iv;
    tick(); tick();
  endtask

  task automatic finish_xfer();
    xfer_done = 1; tick(); xfer_done = 0;
  endtask

  task automatic sof_pulse();
    sof = 1; tick(); sof = 0; tick();
  endtask

  task automatic t_reset();
    expect_out("R11 reset", 5'b0_00_0_0);
  endtask

  task automatic t_gate();
    go_idle(0);
    pipe(2'b01, 0, 2'b01, 1, 0);
    host_mode = 0; bus_active = 1; tick(); tick();
    expect_out("R1 host off", 5'b0_00_0_0);
    host_mode = 1; bus_active = 0; tick(); tick();
    expect_out("R1 bus off", 5'b0_00_0_0);
    bus_active = 1; tick();
    expect_out("R3 bulk IN", 5'b1_10_0_0);
    bus_active = 0; tick();
    expect_out("R1 cancel", 5'b0_00_0_0);
  endtask

  task automatic t_setup();
    go_idle(7);
    pipe(2'b10, 1, 2'b00, 0, 0);
    setup_req = 1; bus_active = 1; tick();
    expect_out("R2 setup", 5'b1_01_0_0);
    setup_req = 0; finish_xfer();
    expect_out("R9 drop after done", 5'b0_00_0_0);
  endtask

  task automatic t_bulk();
    go_idle(9);
    pipe(2'b01, 0, 2'b01, 0, 1);
    bus_active = 1; tick(); tick();
    expect_out("R3 IN no space", 5'b0_00_0_0);
    rx_space = 1; tick();
    expect_out("R3 IN ok", 5'b1_10_0_0);
    rx_space = 0; dir_out = 1; tick(); tick();
    expect_out("R9 held stable", 5'b1_10_0_0);
    finish_xfer();
    expect_out("R9 released", 5'b0_00_0_0);
    pipe(2'b00, 1, 2'b01, 0, 1); tick();
    expect_out("R3 control OUT", 5'b1_11_0_0);
    finish_xfer();
    pipe(2'b00, 1, 2'b01, 0, 0); tick(); tick();
    expect_out("R3 OUT no data", 5'b0_00_0_0);
  endtask

  task automatic t_resp_block();
    go_idle(0);
    pipe(2'b01, 0, 2'b00, 1, 1);
    bus_active = 1; tick(); tick();
    expect_out("R10 NAK bulk", 5'b0_00_0_0);
    pipe(2'b11, 1, 2'b10, 1, 1); tick(); tick();
    expect_out("R10 STALL iso", 5'b0_00_0_0);
  endtask

  task automatic t_interrupt();
    go_idle(2);
    pipe(2'b10, 0, 2'b01, 1, 0);
    bus_active = 1; tick(); tick();
    expect_out("R4 no match yet", 5'b0_00_0_0);
    sof_pulse();
    expect_out("R7 one strobe", 5'b0_00_0_0);
    sof_pulse();
    expect_out("R4 R7 matched frame", 5'b1_10_0_0);
    finish_xfer();
    expect_out("R9 done", 5'b0_00_0_0);
    tick(); tick();
    expect_out("R8 once per frame", 5'b0_00_0_0);
    sof_pulse();
    expect_out("R7 reload", 5'b0_00_0_0);
    sof_pulse();
    expect_out("R7 mid period", 5'b0_00_0_0);
    sof_pulse();
    expect_out("R7 next match", 5'b1_10_0_0);
  endtask

  task automatic t_iso();
    go_idle(0);
    pipe(2'b11, 0, 2'b01, 0, 0);
    bus_active = 1; tick();
    expect_out("R5 iso IN discard", 5'b1_10_0_1);
    finish_xfer(); tick();
    expect_out("R8 iso once", 5'b0_00_0_0);
    rx_space = 1; sof_pulse();
    expect_out("R5 iso IN space", 5'b1_10_0_0);
    finish_xfer();
    pipe(2'b11, 1, 2'b01, 0, 0); sof_pulse();
    expect_out("R6 iso OUT zlp", 5'b1_11_1_0);
    finish_xfer();
    tx_ready = 1; sof_pulse();
    expect_out("R6 iso OUT data", 5'b1_11_0_0);
  endtask

  task automatic t_sof_edge();
    go_idle(0);
    pipe(2'b01, 0, 2'b01, 1, 0);
    bus_active = 1; sof = 1; tick(); sof = 0;
    expect_out("R12 no issue on sof", 5'b0_00_0_0);
    tick();
    expect_out("R12 issue after sof", 5'b1_10_0_0);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    host_mode = 1;
    tick(); tick();
    rst_n = 1; tick();
    t_reset();
    t_gate();
    t_setup();
    t_bulk();
    t_resp_block();
    t_interrupt();
    t_iso();
    t_sof_edge();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule